// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Doorbells

This block is a synchronous true dual-port memory of 16-bit words. Its two ports, left and right, are fully independent. Each port has an enable, a write strobe, a read-output enable and two byte-lane selects. Either port can read or write any word on every clock, and each byte lane of a port can be written or read on its own. The depth is set by the `ADDR_W` parameter. The default is 1024 words.

The two highest addresses also act as doorbells between the ports. Address `DEPTH-2` is the left port's inbox and address `DEPTH-1` is the right port's inbox. When one port writes the other port's inbox, the other port's active-low interrupt goes low. The interrupt returns high when the owning port reads its inbox with its enable and read-output enable both set. The inbox words remain ordinary storage, so the interrupt carries the event and the word carries the message.

Each port has a busy input, driven by collision logic outside the block. While busy is high, that port's writes are dropped, and so are the doorbell sets and clears that the port would cause. Reads on that port are not affected.

Each doorbell is a two-state machine. In `MB_IDLE` the interrupt is high. The transition `RING` (a valid set) moves it to `MB_PENDING`, where the interrupt is low. The transition `ACK` (a valid clear with no set in the same cycle) moves it back to `MB_IDLE`. In every other cycle the state is held.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: While reset (`rst_n` low) is applied, and right after it is released, both `*_irq_n` outputs are 1 and both `*_rvld` outputs are 2'b00.
- R2: A word written on one port is returned on either port's `*_rdata` one clock after the read is sampled. A read is sampled when enable=1, write=0, read-output enable=1. The returned word reflects memory before any write sampled at that same edge.
- R3: Upper select (`*_ub`) covers bits 15:8 and maps to `*_rvld[1]`. Lower select (`*_lb`) covers bits 7:0 and maps to `*_rvld[0]`. A write changes only the selected lanes. On a read, an unselected lane returns 8'h00 with its valid bit 0.
- R4: `*_rvld` is 2'b00 and `*_rdata` is 0 on the cycle after any of these on that port: enable=0, read-output enable=0, or write=1.
- R5: A write by the left port to address `DEPTH-1` drives `r_irq_n` to 0 one clock later. A write by the right port to address `DEPTH-2` drives `l_irq_n` to 0 one clock later.
- R6: A port clears its own interrupt (back to 1 one clock later) when it accesses its own inbox with enable=1 and read-output enable=1; the write strobe is don't-care. Reading the other port's inbox does not clear anything.
- R7: While the writing port's busy is 1, the write does not change memory and does not set a doorbell.
- R8: While the owning port's busy is 1, its inbox access does not clear its interrupt.
- R9: If a set and a clear of the same doorbell fall in the same cycle, the interrupt ends up 0.
- R10: The inbox words hold whatever was last written there and read back like any other location.
- R11: If both ports write the same lane of the same address in one cycle, the right port's data is stored.
- R12: An access with both byte selects 0 writes nothing and neither sets nor clears a doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write strobe (1 = write) |
| l_oe | input | 1 | Left read-output enable |
| l_ub | input | 1 | Left upper byte select (bits 15:8) |
| l_lb | input | 1 | Left lower byte select (bits 7:0) |
| l_busy | input | 1 | Left busy from external collision logic |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, registered |
| l_rvld | output | 2 | Left per-lane read valid, registered |
| l_irq_n | output | 1 | Left doorbell interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write strobe (1 = write) |
| r_oe | input | 1 | Right read-output enable |
| r_ub | input | 1 | Right upper byte select (bits 15:8) |
| r_lb | input | 1 | Right lower byte select (bits 7:0) |
| r_busy | input | 1 | Right busy from external collision logic |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, registered |
| r_rvld | output | 2 | Right per-lane read valid, registered |
| r_irq_n | output | 1 | Right doorbell interrupt, active low |

## Verification
Every result of this block appears exactly one clock after the edge that samples its stimulus. This holds for read data, the lane valid bits, and doorbell sets and clears, because each passes through a single register. The bench drives all inputs just after a falling edge, lets one rising edge sample them, and reads the outputs at the next falling edge, half a period after that edge. Memory contents are confirmed with a separate read that follows the write. Cases where a write or a doorbell action must have no effect are observed on the next cycle through the ports.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic {
        MB_IDLE    = 1'b0,
        MB_PENDING = 1'b1
    } mb_state_t;
endpackage

// File: rtl/dpm_port_dec.sv
module dpm_port_dec
    import dpm_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int OWN_BOX  = 1022,
    parameter int PEER_BOX = 1023
) (
    input  logic              en,
    input  logic              we,
    input  logic              oe,
    input  logic              ub,
    input  logic              lb,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic [LANES-1:0]  rd_lanes,
    output logic              ring_peer,
    output logic              ack_own
);
    localparam logic [ADDR_W-1:0] OWN_A  = OWN_BOX[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PEER_A = PEER_BOX[ADDR_W-1:0];

    logic [LANES-1:0] sel;
    logic             touch;

    always_comb begin
        sel       = {ub, lb};
        touch     = en && (sel != '0);
        wr_lanes  = (en && we && !busy) ? sel : '0;
        rd_lanes  = (en && !we && oe) ? sel : '0;
        ring_peer = touch && we && !busy && (addr == PEER_A);
        ack_own   = touch && oe && !busy && (addr == OWN_A);
    end
endmodule

// File: rtl/dpm_doorbell.sv
module dpm_doorbell
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic ack,
    output logic irq_n
);
    mb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_IDLE:    if (ring) state_d = MB_PENDING;
            MB_PENDING: if (ack && !ring) state_d = MB_IDLE;
            default:    state_d = MB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q == MB_PENDING) ? 1'b0 : 1'b1;
    end

    AST_RING_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ring |=> !irq_n); // R5
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ring) |=> irq_n); // R6
    AST_RING_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && ack) |=> !irq_n); // R9
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring && !ack) |=> $stable(irq_n)); // R8
endmodule

// File: rtl/dpm_array.sv
module dpm_array
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [LANES-1:0]  l_wr,
    input  logic [LANES-1:0]  l_rd,
    output logic [DATA_W-1:0] l_rdata,
    output logic [LANES-1:0]  l_rvld,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic [LANES-1:0]  r_wr,
    input  logic [LANES-1:0]  r_rd,
    output logic [DATA_W-1:0] r_rdata,
    output logic [LANES-1:0]  r_rvld
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] l_q, r_q;
        logic              l_v, r_v;

        // Right-port write placed last so it wins a same-lane collision.
        always_ff @(posedge clk) begin
            if (l_wr[g]) mem[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
            if (r_wr[g]) mem[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                l_q <= '0;
                l_v <= 1'b0;
                r_q <= '0;
                r_v <= 1'b0;
            end else begin
                l_q <= l_rd[g] ? mem[l_addr] : '0;
                l_v <= l_rd[g];
                r_q <= r_rd[g] ? mem[r_addr] : '0;
                r_v <= r_rd[g];
            end
        end

        assign l_rdata[g*LANE_W +: LANE_W] = l_q;
        assign r_rdata[g*LANE_W +: LANE_W] = r_q;
        assign l_rvld[g] = l_v;
        assign r_rvld[g] = r_v;

        AST_IDLE_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!l_rd[g] && !r_rd[g]) |=> (!l_v && !r_v && l_q == '0 && r_q == '0)); // R4
    end
endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic              l_ub,
    input  logic              l_lb,
    input  logic              l_busy,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [15:0]       l_wdata,
    output logic [15:0]       l_rdata,
    output logic [1:0]        l_rvld,
    output logic              l_irq_n,
    input  logic              r_en,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic              r_ub,
    input  logic              r_lb,
    input  logic              r_busy,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [15:0]       r_wdata,
    output logic [15:0]       r_rdata,
    output logic [1:0]        r_rvld,
    output logic              r_irq_n
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int L_BOX  = DEPTH - 2;
    localparam int R_BOX  = DEPTH - 1;

    logic [LANES-1:0] l_wr, l_rd, r_wr, r_rd;
    logic             l_ring, l_ack, r_ring, r_ack;

    dpm_port_dec #(.ADDR_W(ADDR_W), .OWN_BOX(L_BOX), .PEER_BOX(R_BOX)) i_dec_l (
        .en(l_en), .we(l_we), .oe(l_oe), .ub(l_ub), .lb(l_lb), .busy(l_busy),
        .addr(l_addr), .wr_lanes(l_wr), .rd_lanes(l_rd),
        .ring_peer(l_ring), .ack_own(l_ack)
    );

    dpm_port_dec #(.ADDR_W(ADDR_W), .OWN_BOX(R_BOX), .PEER_BOX(L_BOX)) i_dec_r (
        .en(r_en), .we(r_we), .oe(r_oe), .ub(r_ub), .lb(r_lb), .busy(r_busy),
        .addr(r_addr), .wr_lanes(r_wr), .rd_lanes(r_rd),
        .ring_peer(r_ring), .ack_own(r_ack)
    );

    // Left inbox: rung by the right port, acknowledged by the left port.
    dpm_doorbell i_bell_l (
        .clk(clk), .rst_n(rst_n), .ring(r_ring), .ack(l_ack), .irq_n(l_irq_n)
    );

    // Right inbox: rung by the left port, acknowledged by the right port.
    dpm_doorbell i_bell_r (
        .clk(clk), .rst_n(rst_n), .ring(l_ring), .ack(r_ack), .irq_n(r_irq_n)
    );

    dpm_array #(.ADDR_W(ADDR_W)) i_array (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_wr(l_wr), .l_rd(l_rd),
        .l_rdata(l_rdata), .l_rvld(l_rvld),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_wr(r_wr), .r_rd(r_rd),
        .r_rdata(r_rdata), .r_rvld(r_rvld)
    );

    AST_BUSY_NO_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy && !r_ring && !r_ack && r_irq_n) |=> r_irq_n); // R7
    AST_NOSEL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ub && !l_lb) |=> (l_rvld == 2'b00)); // R12
endmodule

// File: tb/test_dpm_mailbox_ram.sv
`timescale 1ns/1ps
module test_dpm_mailbox_ram;
    localparam int AW  = 10;
    localparam logic [AW-1:0] MBL = 10'h3FE;
    localparam logic [AW-1:0] MBR = 10'h3FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en, l_we, l_oe, l_ub, l_lb, l_busy;
    logic r_en, r_we, r_oe, r_ub, r_lb, r_busy;
    logic [AW-1:0] l_addr, r_addr;
    logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic [1:0] l_rvld, r_rvld;
    logic l_irq_n, r_irq_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dpm_mailbox_ram #(.ADDR_W(AW)) i_dpm_mailbox_ram (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
        .l_busy(l_busy), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rvld(l_rvld), .l_irq_n(l_irq_n),
        .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
        .r_busy(r_busy), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rvld(r_rvld), .r_irq_n(r_irq_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_l(input logic en, we, oe, ub, lb, busy,
                         input logic [AW-1:0] a, input logic [15:0] d);
        l_en = en; l_we = we; l_oe = oe; l_ub = ub; l_lb = lb;
        l_busy = busy; l_addr = a; l_wdata = d;
    endtask

    task automatic set_r(input logic en, we, oe, ub, lb, busy,
                         input logic [AW-1:0] a, input logic [15:0] d);
        r_en = en; r_we = we; r_oe = oe; r_ub = ub; r_lb = lb;
        r_busy = busy; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        set_l(0, 0, 0, 0, 0, 0, '0, '0);
        set_r(0, 0, 0, 0, 0, 0, '0, '0);
    endtask

    // Inputs change after a falling edge; one rising edge samples them;
    // outputs are read at the following falling edge.
    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic lwrite(input logic [AW-1:0] a, input logic [15:0] d);
        set_l(1, 1, 0, 1, 1, 0, a, d); cycle(); idle();
    endtask

    task automatic lread(input logic [AW-1:0] a);
        set_l(1, 0, 1, 1, 1, 0, a, '0); cycle(); idle();
    endtask

    task automatic rread(input logic [AW-1:0] a);
        set_r(1, 0, 1, 1, 1, 0, a, '0); cycle(); idle();
    endtask

    task automatic t_reset();
        chk("R1", "l_irq_n", l_irq_n, 1);
        chk("R1", "r_irq_n", r_irq_n, 1);
        chk("R1", "l_rvld", l_rvld, 0);
        chk("R1", "r_rvld", r_rvld, 0);
    endtask

    task automatic t_basic();
        lwrite(10'h010, 16'hA5C3);
        rread(10'h010);
        chk("R2", "cross-port rdata", r_rdata, 16'hA5C3);
        chk("R2", "cross-port rvld", r_rvld, 2'b11);
        lwrite(10'h020, 16'h1234);
        lread(10'h020);
        chk("R2", "same-port rdata", l_rdata, 16'h1234);
    endtask

    task automatic t_bytes();
        lwrite(10'h030, 16'hFFFF);
        set_l(1, 1, 0, 1, 0, 0, 10'h030, 16'h1234); cycle(); idle();
        lread(10'h030);
        chk("R3", "upper-only write", l_rdata, 16'h12FF);
        set_l(1, 0, 1, 1, 0, 0, 10'h030, '0); cycle(); idle();
        chk("R3", "upper read data", l_rdata, 16'h1200);
        chk("R3", "upper read vld", l_rvld, 2'b10);
        set_r(1, 0, 1, 0, 1, 0, 10'h030, '0); cycle(); idle();
        chk("R3", "lower read data", r_rdata, 16'h00FF);
        chk("R3", "lower read vld", r_rvld, 2'b01);
    endtask

    task automatic t_disabled();
        set_l(0, 0, 1, 1, 1, 0, 10'h030, '0); cycle(); idle();
        chk("R4", "en low vld", l_rvld, 0);
        set_l(1, 0, 0, 1, 1, 0, 10'h030, '0); cycle(); idle();
        chk("R4", "oe low vld", l_rvld, 0);
        chk("R4", "oe low data", l_rdata, 0);
        set_r(1, 1, 1, 1, 1, 0, 10'h060, 16'h9999); cycle(); idle();
        chk("R4", "write vld", r_rvld, 0);
    endtask

    task automatic t_nosel();
        set_l(1, 1, 0, 0, 0, 0, 10'h030, 16'h0000); cycle(); idle();
        lread(10'h030);
        chk("R12", "no-select write ignored", l_rdata, 16'h12FF);
        set_l(1, 1, 0, 0, 0, 0, MBR, 16'h0000); cycle(); idle();
        chk("R12", "no-select no ring", r_irq_n, 1);
    endtask

    task automatic t_mail();
        lwrite(MBR, 16'hBEEF);
        chk("R5", "right irq set", r_irq_n, 0);
        chk("R5", "left irq untouched", l_irq_n, 1);
        lread(MBR);
        chk("R6", "non-owner read keeps irq", r_irq_n, 0);
        rread(MBR);
        chk("R10", "inbox word readback", r_rdata, 16'hBEEF);
        chk("R6", "owner read clears", r_irq_n, 1);
        set_r(1, 1, 0, 1, 1, 0, MBL, 16'h0F0F); cycle(); idle();
        chk("R5", "left irq set", l_irq_n, 0);
        set_l(1, 1, 1, 1, 1, 0, MBL, 16'h5555); cycle(); idle();
        chk("R6", "clear with write strobe", l_irq_n, 1);
        lread(MBL);
        chk("R10", "inbox written as storage", l_rdata, 16'h5555);
    endtask

    task automatic t_busy();
        lwrite(10'h040, 16'h1111);
        set_l(1, 1, 0, 1, 1, 1, 10'h040, 16'h7777); cycle(); idle();
        lread(10'h040);
        chk("R7", "busy write dropped", l_rdata, 16'h1111);
        set_l(1, 1, 0, 1, 1, 1, MBR, 16'h6666); cycle(); idle();
        chk("R7", "busy write no ring", r_irq_n, 1);
        lwrite(MBR, 16'h2222);
        chk("R7", "unbusy ring", r_irq_n, 0);
        set_r(1, 0, 1, 1, 1, 1, MBR, '0); cycle(); idle();
        chk("R8", "busy owner no clear", r_irq_n, 0);
        rread(MBR);
        chk("R8", "clear after busy drops", r_irq_n, 1);
    endtask

    task automatic t_setwins();
        set_l(1, 1, 0, 1, 1, 0, MBR, 16'h3333);
        set_r(1, 0, 1, 1, 1, 0, MBR, '0);
        cycle(); idle();
        chk("R9", "set beats clear", r_irq_n, 0);
        rread(MBR);
        chk("R9", "later clear", r_irq_n, 1);
    endtask

    task automatic t_collide();
        set_l(1, 1, 0, 1, 1, 0, 10'h050, 16'hAAAA);
        set_r(1, 1, 0, 1, 1, 0, 10'h050, 16'h5555);
        cycle(); idle();
        lread(10'h050);
        chk("R11", "right wins full word", l_rdata, 16'h5555);
        set_l(1, 1, 0, 1, 1, 0, 10'h050, 16'h1122);
        set_r(1, 1, 0, 1, 0, 0, 10'h050, 16'h3300);
        cycle(); idle();
        rread(10'h050);
        chk("R11", "right wins upper lane only", r_rdata, 16'h3322);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cycle();
        t_reset();
        t_basic();
        t_bytes();
        t_disabled();
        t_nosel();
        t_mail();
        t_busy();
        t_setwins();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule